// File: doc/BRIEF.md
# Word-Width-Aware Transmit/Receive FIFO Pair with Threshold Interrupts

This block holds the transmit and receive queues of a serial peripheral. Both queues share one fixed byte budget of 16 bytes per direction. The number of entries each queue can hold depends on the active word width: 16 entries for 8-bit words, 8 for 16-bit words and 4 for 32-bit words. The register side pushes words into the transmit queue and pops words from the receive queue. The shifter side pops from the transmit queue and pushes into the receive queue.

Each direction has its own 2-bit interrupt mode, which selects the fill condition that raises its interrupt line. A receive push that meets a full queue is dropped and can raise a sticky overflow flag. A transmit pop that meets an empty queue can raise a sticky underrun flag. Each flag has its own enable and its own clear. The fill levels, the receive-empty indication and both flags are also gathered into one 32-bit status word.

A new word width takes effect only while both queues are empty and idle. Until that moment the old width stays in force.

Top module: `spiq_fifo_pair`

## Requirements
- R1: After reset and with width code 0 the active width is 8 bits. Width code 0 gives a depth of 16 entries, code 1 gives 8 entries, and code 2 or 3 gives 4 entries. `txLevel` and `rxLevel` report the entry counts, from 0 up to the depth.
- R2: Each queue returns words in the order they were written. A word is stored truncated to the active width, and its unused upper bits read as zero. The head word is presented on `shRdata` (transmit) or `regRdata` (receive) whenever the queue is not empty.
- R3: A register push to a full transmit queue is ignored: the level and the stored contents do not change.
- R4: A shifter push to a full receive queue is dropped. If `ovfEn` is high, `ovfFlag` is set one cycle later. The flag stays set until a cycle with `clrOvf` high. A new overflow in the same cycle as the clear wins. With `ovfEn` low the flag is not set.
- R5: A shifter pop from an empty transmit queue leaves the level at 0. If `urEn` is high, `urFlag` is set one cycle later and stays set until `clrUr`. With `urEn` low the flag is not set.
- R6: `rxIrq` follows `rxMode`: 0 means the queue is empty, 1 means not empty, 2 means the level is at least half the depth, and 3 means the level equals the depth.
- R7: `txIrq` follows `txMode`: 0 means the queue is empty and `shIdle` is high, 1 means the queue is empty, 2 means the free entries are at least half the depth, and 3 means at least one entry is free.
- R8: The `status` field positions are fixed. Bit 5 is receive-empty, bit 6 is `ovfFlag`, bit 8 is `urFlag`, bits 20:16 are the transmit level and bits 28:24 are the receive level. All other bits are zero.
- R9: A change of `wordSize` is applied at the first clock edge where both queues are empty and no push is requested on either side. That edge also returns all read and write positions to the start. Until then the previous width, depth and truncation stay in force.
- R10: Reset empties both queues and clears both flags. The status word then reads 0x20.
- R11: A push and a pop on the same queue in the same cycle both take effect when the queue is neither full nor empty. The level is then unchanged and the word order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wordSize | input | 2 | Requested word width code (0: 8, 1: 16, 2/3: 32 bits) |
| txMode | input | 2 | Transmit interrupt condition select |
| rxMode | input | 2 | Receive interrupt condition select |
| ovfEn | input | 1 | Enable for setting the overflow flag |
| urEn | input | 1 | Enable for setting the underrun flag |
| clrOvf | input | 1 | Clears the overflow flag |
| clrUr | input | 1 | Clears the underrun flag |
| regPush | input | 1 | Register-side write into the transmit queue |
| regWdata | input | 32 | Word written into the transmit queue |
| regPop | input | 1 | Register-side read from the receive queue |
| regRdata | output | 32 | Head word of the receive queue |
| shPop | input | 1 | Shifter-side read from the transmit queue |
| shRdata | output | 32 | Head word of the transmit queue |
| shPush | input | 1 | Shifter-side write into the receive queue |
| shWdata | input | 32 | Word written into the receive queue |
| shIdle | input | 1 | Shifter has no word in flight |
| txLevel | output | 5 | Transmit queue entry count |
| rxLevel | output | 5 | Receive queue entry count |
| txIrq | output | 1 | Transmit interrupt request |
| rxIrq | output | 1 | Receive interrupt request |
| ovfFlag | output | 1 | Sticky receive overflow flag |
| urFlag | output | 1 | Sticky transmit underrun flag |
| status | output | 32 | Packed status word |

## Verification
Some properties are checked on every cycle by assertions in the control logic:
- the levels never exceed the active depth;
- a full transmit queue does not grow;
- the overflow and underrun flags get set when enabled;
- the overflow flag does not drop without a clear;
- the active width changes only after both queues were empty.

Other properties only the bench scenarios can show: word order and truncation per width, the interrupt condition for every mode at every fill level, the status field placement, and the deferred width change, which is observed through depth and truncation.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
  localparam int STORE_BYTES = 16;
  localparam int MAX_WIDTH   = 32;
  localparam int PTR_W       = $clog2(STORE_BYTES);
  localparam int LEVEL_W     = PTR_W + 1;

  // Strobes from control to datapath
  typedef struct packed {
    logic                 txWe;
    logic                 rxWe;
    logic [PTR_W-1:0]     txWrAddr;
    logic [PTR_W-1:0]     txRdAddr;
    logic [PTR_W-1:0]     rxWrAddr;
    logic [PTR_W-1:0]     rxRdAddr;
    logic [MAX_WIDTH-1:0] mask;
  } strobe_t;
endpackage

// File: rtl/spiq_data.sv
module spiq_data
  import spiq_pkg::*;
(
  input  logic                 clk,
  input  strobe_t              stb,
  input  logic [MAX_WIDTH-1:0] txWdata,
  input  logic [MAX_WIDTH-1:0] rxWdata,
  output logic [MAX_WIDTH-1:0] txHead,
  output logic [MAX_WIDTH-1:0] rxHead
);
  localparam int SIDES = 2;  // index 0: transmit, 1: receive

  logic [SIDES-1:0][MAX_WIDTH-1:0] wIn;
  logic [SIDES-1:0][MAX_WIDTH-1:0] rOut;
  logic [SIDES-1:0]                we;
  logic [SIDES-1:0][PTR_W-1:0]     wAddr;
  logic [SIDES-1:0][PTR_W-1:0]     rAddr;

  assign wIn   = {rxWdata, txWdata};
  assign we    = {stb.rxWe, stb.txWe};
  assign wAddr = {stb.rxWrAddr, stb.txWrAddr};
  assign rAddr = {stb.rxRdAddr, stb.txRdAddr};

  for (genvar g = 0; g < SIDES; g++) begin : g_side
    logic [MAX_WIDTH-1:0] mem [STORE_BYTES];
    always_ff @(posedge clk) begin
      if (we[g]) mem[wAddr[g]] <= wIn[g] & stb.mask;
    end
    assign rOut[g] = mem[rAddr[g]] & stb.mask;
  end

  assign txHead = rOut[0];
  assign rxHead = rOut[1];
endmodule

// File: rtl/spiq_ctrl.sv
module spiq_ctrl
  import spiq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         wordSize,
  input  logic [1:0]         txMode,
  input  logic [1:0]         rxMode,
  input  logic               ovfEn,
  input  logic               urEn,
  input  logic               clrOvf,
  input  logic               clrUr,
  input  logic               regPush,
  input  logic               regPop,
  input  logic               shPop,
  input  logic               shPush,
  input  logic               shIdle,
  output strobe_t            stb,
  output logic [LEVEL_W-1:0] txLevel,
  output logic [LEVEL_W-1:0] rxLevel,
  output logic               txIrq,
  output logic               rxIrq,
  output logic               ovfFlag,
  output logic               urFlag
);
  logic [1:0]         activeSize, reqSize;
  logic [LEVEL_W-1:0] depth, half;
  logic [PTR_W-1:0]   txWr, txRd, rxWr, rxRd;
  logic txFull, txEmpty, rxFull, rxEmpty;
  logic txPushOk, txPopOk, rxPushOk, rxPopOk, sizeChg;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p,
                                            input logic [LEVEL_W-1:0] d);
    return (LEVEL_W'(p) == d - 1'b1) ? '0 : p + 1'b1;
  endfunction

  assign reqSize = (wordSize == 2'd3) ? 2'd2 : wordSize;
  assign depth   = LEVEL_W'(STORE_BYTES >> activeSize);
  assign half    = depth >> 1;

  assign txFull  = (txLevel == depth);
  assign txEmpty = (txLevel == '0);
  assign rxFull  = (rxLevel == depth);
  assign rxEmpty = (rxLevel == '0);

  assign txPushOk = regPush && !txFull;
  assign txPopOk  = shPop && !txEmpty;
  assign rxPushOk = shPush && !rxFull;
  assign rxPopOk  = regPop && !rxEmpty;
  assign sizeChg  = (reqSize != activeSize) && txEmpty && rxEmpty && !regPush && !shPush;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeSize <= 2'd0;
      txWr <= '0; txRd <= '0; rxWr <= '0; rxRd <= '0;
      txLevel <= '0; rxLevel <= '0;
      ovfFlag <= 1'b0; urFlag <= 1'b0;
    end else begin
      if (sizeChg) begin
        activeSize <= reqSize;
        txWr <= '0; txRd <= '0; rxWr <= '0; rxRd <= '0;
      end else begin
        if (txPushOk) txWr <= bump(txWr, depth);
        if (txPopOk)  txRd <= bump(txRd, depth);
        if (rxPushOk) rxWr <= bump(rxWr, depth);
        if (rxPopOk)  rxRd <= bump(rxRd, depth);
      end
      txLevel <= txLevel + LEVEL_W'(txPushOk) - LEVEL_W'(txPopOk);
      rxLevel <= rxLevel + LEVEL_W'(rxPushOk) - LEVEL_W'(rxPopOk);
      ovfFlag <= (ovfFlag && !clrOvf) || (shPush && rxFull && ovfEn);
      urFlag  <= (urFlag && !clrUr) || (shPop && txEmpty && urEn);
    end
  end

  always_comb begin
    stb.txWe     = txPushOk;
    stb.rxWe     = rxPushOk;
    stb.txWrAddr = txWr;
    stb.txRdAddr = txRd;
    stb.rxWrAddr = rxWr;
    stb.rxRdAddr = rxRd;
    stb.mask     = {MAX_WIDTH{1'b1}} >> (MAX_WIDTH - (8 << activeSize));
  end

  always_comb begin
    unique case (rxMode)
      2'd0:    rxIrq = rxEmpty;
      2'd1:    rxIrq = !rxEmpty;
      2'd2:    rxIrq = (rxLevel >= half);
      default: rxIrq = rxFull;
    endcase
    unique case (txMode)
      2'd0:    txIrq = txEmpty && shIdle;
      2'd1:    txIrq = txEmpty;
      2'd2:    txIrq = ((depth - txLevel) >= half);
      default: txIrq = !txFull;
    endcase
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel <= depth) && (rxLevel <= depth)); // R1

  AST_TX_FULL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel == depth && regPush && !shPop) |=> (txLevel == $past(txLevel))); // R3

  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel == depth && shPush && ovfEn) |=> ovfFlag); // R4

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !clrOvf) |=> ovfFlag); // R4

  AST_UR_SET: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel == '0 && shPop && urEn) |=> (urFlag && txLevel == '0)); // R5

  AST_SIZE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (activeSize != $past(activeSize)) |-> ($past(txLevel) == '0 && $past(rxLevel) == '0)); // R9
endmodule

// File: rtl/spiq_fifo_pair.sv
module spiq_fifo_pair
  import spiq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           wordSize,
  input  logic [1:0]           txMode,
  input  logic [1:0]           rxMode,
  input  logic                 ovfEn,
  input  logic                 urEn,
  input  logic                 clrOvf,
  input  logic                 clrUr,
  input  logic                 regPush,
  input  logic [MAX_WIDTH-1:0] regWdata,
  input  logic                 regPop,
  output logic [MAX_WIDTH-1:0] regRdata,
  input  logic                 shPop,
  output logic [MAX_WIDTH-1:0] shRdata,
  input  logic                 shPush,
  input  logic [MAX_WIDTH-1:0] shWdata,
  input  logic                 shIdle,
  output logic [LEVEL_W-1:0]   txLevel,
  output logic [LEVEL_W-1:0]   rxLevel,
  output logic                 txIrq,
  output logic                 rxIrq,
  output logic                 ovfFlag,
  output logic                 urFlag,
  output logic [31:0]          status
);
  localparam int RXE_BIT = 5;
  localparam int OVF_BIT = 6;
  localparam int UR_BIT  = 8;
  localparam int TXL_LSB = 16;
  localparam int RXL_LSB = 24;

  strobe_t stb;

  spiq_ctrl i_ctrl (
    .clk, .rstN, .wordSize, .txMode, .rxMode, .ovfEn, .urEn, .clrOvf, .clrUr,
    .regPush, .regPop, .shPop, .shPush, .shIdle,
    .stb, .txLevel, .rxLevel, .txIrq, .rxIrq, .ovfFlag, .urFlag
  );

  spiq_data i_data (
    .clk, .stb,
    .txWdata(regWdata), .rxWdata(shWdata),
    .txHead(shRdata), .rxHead(regRdata)
  );

  always_comb begin
    status = '0;
    status[RXE_BIT] = (rxLevel == '0);
    status[OVF_BIT] = ovfFlag;
    status[UR_BIT]  = urFlag;
    status[TXL_LSB +: LEVEL_W] = txLevel;
    status[RXL_LSB +: LEVEL_W] = rxLevel;
  end
endmodule

// File: tb/test_spiq_fifo_pair.sv
`timescale 1ns/1ps
module test_spiq_fifo_pair;
  logic clk = 0, rstN = 0;
  logic [1:0] wordSize = 0, txMode = 0, rxMode = 0;
  logic ovfEn = 0, urEn = 0, clrOvf = 0, clrUr = 0;
  logic regPush = 0, regPop = 0, shPop = 0, shPush = 0, shIdle = 0;
  logic [31:0] regWdata = 0, shWdata = 0, regRdata, shRdata, status;
  logic [4:0] txLevel, rxLevel;
  logic txIrq, rxIrq, ovfFlag, urFlag;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  spiq_fifo_pair i_spiq_fifo_pair (.*);

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int i, input int sz);
    return (32'h9E3779B9 * 32'(i + 1)) ^ (32'(sz) << 28);
  endfunction

  function automatic logic [31:0] stExp(input int rxL, input int txL, input bit ur,
                                        input bit ovf);
    return (32'(rxL) << 24) | (32'(txL) << 16) | (32'(ur) << 8) | (32'(ovf) << 6)
         | (32'(rxL == 0) << 5);
  endfunction

  task automatic sweepTx(input int lvl, input int dep);
    for (int m = 0; m < 4; m++) begin
      for (int idl = 0; idl < 2; idl++) begin
        bit e;
        txMode = 2'(m); shIdle = idl[0]; #1;
        case (m)
          0: e = (lvl == 0) && idl[0];
          1: e = (lvl == 0);
          2: e = (dep - lvl) >= dep / 2;
          default: e = lvl < dep;
        endcase
        chk($sformatf("R7 txIrq mode %0d level %0d", m, lvl), 32'(txIrq), 32'(e));
      end
    end
  endtask

  task automatic sweepRx(input int lvl, input int dep);
    for (int m = 0; m < 4; m++) begin
      bit e;
      rxMode = 2'(m); #1;
      case (m)
        0: e = (lvl == 0);
        1: e = (lvl != 0);
        2: e = lvl >= dep / 2;
        default: e = (lvl == dep);
      endcase
      chk($sformatf("R6 rxIrq mode %0d level %0d", m, lvl), 32'(rxIrq), 32'(e));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rstN = 1; tick();
    // R10 reset state
    chk("R10 txLevel", 32'(txLevel), 0);
    chk("R10 rxLevel", 32'(rxLevel), 0);
    chk("R10 flags", {30'd0, ovfFlag, urFlag}, 0);
    chk("R10 status", status, 32'h20);

    for (int sz = 0; sz < 3; sz++) begin
      int dep;
      logic [31:0] msk;
      bit oe;
      dep = 16 >> sz;
      msk = (sz == 2) ? 32'hFFFF_FFFF : (sz == 1) ? 32'h0000_FFFF : 32'h0000_00FF;
      wordSize = 2'(sz); tick(); tick();
      sweepTx(0, dep);
      // Fill transmit queue one past depth: R1, R3
      for (int i = 0; i <= dep; i++) begin
        int l;
        regPush = 1; regWdata = pat(i, sz); tick(); regPush = 0;
        l = (i + 1 > dep) ? dep : i + 1;
        chk($sformatf("R1 R3 txLevel size %0d", sz), 32'(txLevel), 32'(l));
        sweepTx(l, dep);
      end
      // Drain with order and truncation: R2
      for (int i = 0; i < dep; i++) begin
        chk($sformatf("R2 shRdata size %0d idx %0d", sz, i), shRdata, pat(i, sz) & msk);
        shPop = 1; tick(); shPop = 0;
        chk("R2 txLevel drain", 32'(txLevel), 32'(dep - i - 1));
      end
      // Underrun: R5
      urEn = 0; shPop = 1; tick(); shPop = 0;
      chk("R5 no flag when disabled", 32'(urFlag), 0);
      urEn = 1; shPop = 1; tick(); shPop = 0;
      chk("R5 level stays 0", 32'(txLevel), 0);
      chk("R5 urFlag set", 32'(urFlag), 1);
      tick();
      chk("R5 urFlag sticky", 32'(urFlag), 1);
      chk("R8 status ur", status, stExp(0, 0, 1, 0));
      clrUr = 1; tick(); clrUr = 0;
      chk("R5 urFlag cleared", 32'(urFlag), 0);
      // Receive fill past depth: R4, R6
      oe = (sz != 1);
      ovfEn = oe;
      sweepRx(0, dep);
      for (int i = 0; i <= dep; i++) begin
        int l;
        shPush = 1; shWdata = pat(i + 20, sz); tick(); shPush = 0;
        l = (i + 1 > dep) ? dep : i + 1;
        chk($sformatf("R1 rxLevel size %0d", sz), 32'(rxLevel), 32'(l));
        sweepRx(l, dep);
      end
      chk("R4 ovfFlag after full push", 32'(ovfFlag), 32'(oe));
      chk("R8 status full rx", status, stExp(dep, 0, 0, oe));
      tick();
      chk("R4 ovfFlag sticky", 32'(ovfFlag), 32'(oe));
      clrOvf = 1; tick(); clrOvf = 0;
      chk("R4 ovfFlag cleared", 32'(ovfFlag), 0);
      for (int i = 0; i < dep; i++) begin
        chk($sformatf("R2 regRdata size %0d idx %0d", sz, i), regRdata, pat(i + 20, sz) & msk);
        regPop = 1; tick(); regPop = 0;
      end
      chk("R8 status drained", status, stExp(0, 0, 0, 0));
      ovfEn = 0;
    end

    // R11: simultaneous push and pop (width 32, depth 4)
    regPush = 1; regWdata = 32'hAAAA0001; tick();
    regWdata = 32'hAAAA0002; tick();
    regWdata = 32'hAAAA0003; shPop = 1; tick(); regPush = 0; shPop = 0;
    chk("R11 txLevel unchanged", 32'(txLevel), 2);
    chk("R11 order head", shRdata, 32'hAAAA0002);
    shPop = 1; tick(); shPop = 0;
    chk("R11 order next", shRdata, 32'hAAAA0003);
    shPop = 1; tick(); shPop = 0;
    shPush = 1; shWdata = 32'h5; tick();
    shWdata = 32'h6; regPop = 1; tick(); shPush = 0; regPop = 0;
    chk("R11 rxLevel unchanged", 32'(rxLevel), 1);
    chk("R11 rx head", regRdata, 32'h6);
    regPop = 1; tick(); regPop = 0;

    // R9: deferred width change while transmit queue holds data
    regPush = 1; regWdata = 32'h1234_5678; tick(); regPush = 0;
    wordSize = 2'd0; tick(); tick(); tick();
    for (int i = 0; i < 5; i++) begin
      regPush = 1; regWdata = 32'hBEEF_0000 + 32'(i); tick(); regPush = 0;
    end
    chk("R9 old depth kept", 32'(txLevel), 4);
    chk("R9 old width kept", shRdata, 32'h1234_5678);
    for (int i = 0; i < 4; i++) begin shPop = 1; tick(); shPop = 0; end
    tick(); tick();
    for (int i = 0; i < 5; i++) begin
      regPush = 1; regWdata = 32'hCAFE_0010 + 32'(i); tick(); regPush = 0;
    end
    chk("R9 new depth applied", 32'(txLevel), 5);
    chk("R9 new width truncates", shRdata, 32'h10);
    for (int i = 0; i < 5; i++) begin shPop = 1; tick(); shPop = 0; end
    chk("R9 drained", 32'(txLevel), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule